// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block keeps the state a program sequencer needs to run nested loops with no branch overhead. It holds three stacks. The loop stack stores, for each active loop, the last instruction address of the body and a 4-bit exit condition code. The return stack stores the first instruction address of each loop body. The count stack saves outer loop counts while an inner loop uses the single live counter.

Every cycle the sequencer presents its fetch address. When that address equals the end address of the innermost loop, the block decides whether the loop ends. For the counter-expired code it tests the live counter. For any other code it uses an externally evaluated condition bit. If the loop continues, the block gives the sequencer the top-of-loop address to branch to. If the loop ends, it unwinds its stacks.

Software can also load the counter (with or without saving the old value), start loops and pop stacks by hand. Misuse of a stack is recorded in a sticky error flag.

Top module: `loop_nest_ctrl`

## Requirements
- R1: After reset all three stacks are empty, the counter reads 0, the error flag is 0 and no loop-end is reported.
- R2: A counter write (`cnt_wr`) saves the current counter value on the count stack and loads `cnt_wdata` at the next clock edge. The count stack holds 4 entries, and `cnt_full` is high while it holds 4.
- R3: A counter overwrite (`cnt_owr`) loads `cnt_wdata` without touching the count stack.
- R4: A count pop (`pop_cnt`) loads the counter with the most recently saved count and removes that entry.
- R5: A loop start pushes {`start_end_addr`, `start_cond`} onto the 4-entry loop stack and `start_top_addr` onto the 16-entry return stack in the same edge.
- R6: `loop_end_hit` is high in the same cycle whenever the loop stack is not empty and `fetch_addr` equals the end address on top of it. It is never high while the loop stack is empty.
- R7: With condition code 4'hE (counter expired) on top, a hit decides as follows:
  - If the counter is not 1, the block raises `loop_back` with `back_addr` equal to the top of the return stack, and the counter decrements by one at the clock edge.
  - If the counter is 1, the block raises `loop_exit` instead.
  - `cnt_expired` is high exactly when the counter equals 1.
- R8: With any other condition code on top, a hit gives `loop_exit` when `cond_met` is 1 and `loop_back` when it is 0, and the counter is left alone.
- R9: On `loop_exit` the loop stack and the return stack are each popped once. If the exiting code was 4'hE, the counter is also reloaded from the count stack, which is popped.
- R10: In a hit cycle all commands are ignored. Otherwise `cnt_wr` beats `cnt_owr`, which beats `pop_cnt`, and `loop_start` beats `pop_loop`.
- R11: A push onto a full stack or a pop from an empty stack sets `stk_err`, which stays set until reset. The offending command changes no stack and does not change the counter.
- R12: A manual `pop_loop` removes only the top loop-stack entry; the return stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_start | input | 1 | Begin a loop |
| start_end_addr | input | 14 | Last body address of the new loop |
| start_cond | input | 4 | Exit condition code of the new loop |
| start_top_addr | input | 14 | First body address of the new loop |
| cnt_wr | input | 1 | Load counter, saving old value |
| cnt_owr | input | 1 | Load counter without saving |
| cnt_wdata | input | 14 | Value for counter loads |
| pop_loop | input | 1 | Manually drop top loop entry |
| pop_cnt | input | 1 | Restore counter from count stack |
| fetch_addr | input | 14 | Current fetch address |
| cond_met | input | 1 | External result for codes other than 4'hE |
| loop_end_hit | output | 1 | Fetch address is innermost loop end |
| loop_back | output | 1 | Branch to top of loop |
| loop_exit | output | 1 | Innermost loop terminates |
| back_addr | output | 14 | Top-of-loop branch target |
| cnt_value | output | 14 | Live counter |
| cnt_expired | output | 1 | Counter equals 1 |
| loop_full | output | 1 | Loop stack full |
| loop_empty | output | 1 | Loop stack empty |
| cnt_full | output | 1 | Count stack full |
| cnt_empty | output | 1 | Count stack empty |
| ret_full | output | 1 | Return stack full |
| ret_empty | output | 1 | Return stack empty |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench targets these corner cases:
- **Last pass of a counted loop.** A design that tested for zero instead of one would run one extra pass.
- **Two nested loops, inner non-counted, outer counted.** The outer count must come back from the count stack when the outer loop ends. A design that popped the count stack on every exit would corrupt the outer count.
- **Commands arriving in a hit cycle, and conflicting commands.** A design without the stated priorities would push twice or load the wrong value.
- **Overflow and underflow on each stack, including a counted exit with an empty count stack.** A design that let an illegal push through would lose the error or silently overwrite the counter.

// File: rtl/lnc_pkg.sv
`timescale 1ns/1ps
package lnc_pkg;
  localparam int LNC_AW  = 14;
  localparam int LNC_CCW = 4;
  localparam logic [LNC_CCW-1:0] LNC_CC_CE = 4'hE;

  typedef struct packed {
    logic [LNC_AW-1:0]  end_addr;
    logic [LNC_CCW-1:0] cond;
  } loop_ent_t;
endpackage

// File: rtl/lnc_lifo.sv
`timescale 1ns/1ps
module lnc_lifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int UW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [UW-1:0] used_q, used_d;
  logic          do_push, do_pop;
  logic [IW-1:0] wr_idx, rd_idx;

  always_comb begin
    full    = (used_q == UW'(DEPTH));
    empty   = (used_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty && !push;
    wr_idx  = IW'(used_q);
    rd_idx  = empty ? '0 : IW'(used_q - UW'(1));
    used_d  = used_q;
    if (do_push)     used_d = used_q + UW'(1);
    else if (do_pop) used_d = used_q - UW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wen;
    assign wen = do_push && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (wen) mem[g] <= wdata;
    end
  end

  assign top = mem[rd_idx];
endmodule

// File: rtl/lnc_counter.sv
`timescale 1ns/1ps
module lnc_counter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_new,
  input  logic [CW-1:0] new_val,
  input  logic          ld_restore,
  input  logic [CW-1:0] restore_val,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic          expired
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld_new || ld_restore || dec;
    cnt_d  = cnt_q;
    if (ld_new)          cnt_d = new_val;
    else if (ld_restore) cnt_d = restore_val;
    else if (dec)        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(1));
endmodule

// File: rtl/loop_nest_ctrl.sv
`timescale 1ns/1ps
module loop_nest_ctrl
  import lnc_pkg::*;
#(
  parameter int CW         = 14,
  parameter int CNT_DEPTH  = 4,
  parameter int LOOP_DEPTH = 4,
  parameter int RET_DEPTH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loop_start,
  input  logic [LNC_AW-1:0]  start_end_addr,
  input  logic [LNC_CCW-1:0] start_cond,
  input  logic [LNC_AW-1:0]  start_top_addr,
  input  logic               cnt_wr,
  input  logic               cnt_owr,
  input  logic [CW-1:0]      cnt_wdata,
  input  logic               pop_loop,
  input  logic               pop_cnt,
  input  logic [LNC_AW-1:0]  fetch_addr,
  input  logic               cond_met,
  output logic               loop_end_hit,
  output logic               loop_back,
  output logic               loop_exit,
  output logic [LNC_AW-1:0]  back_addr,
  output logic [CW-1:0]      cnt_value,
  output logic               cnt_expired,
  output logic               loop_full,
  output logic               loop_empty,
  output logic               cnt_full,
  output logic               cnt_empty,
  output logic               ret_full,
  output logic               ret_empty,
  output logic               stk_err
);
  localparam int LW = $bits(loop_ent_t);

  loop_ent_t         loop_top, loop_new;
  logic [LNC_AW-1:0] ret_top;
  logic [CW-1:0]     cs_top;
  logic              top_is_ce, top_done, cmd_ok;
  logic              lp_push, lp_pop, rt_push, rt_pop, cs_push, cs_pop;
  logic              owr_take, pcnt_take, ploop_take, start_take;
  logic              cnt_ld_new, cnt_restore, cnt_dec;
  logic              err_set, err_q, err_d;

  // loop end detection
  always_comb begin
    loop_end_hit = !loop_empty && (fetch_addr == loop_top.end_addr);
    top_is_ce    = (loop_top.cond == LNC_CC_CE);
    top_done     = top_is_ce ? cnt_expired : cond_met;
    loop_exit    = loop_end_hit && top_done;
    loop_back    = loop_end_hit && !top_done;
    back_addr    = ret_top;
  end

  // command arbitration
  always_comb begin
    cmd_ok     = !loop_end_hit;
    start_take = cmd_ok && loop_start;
    ploop_take = cmd_ok && !loop_start && pop_loop;
    owr_take   = cmd_ok && !cnt_wr && cnt_owr;
    pcnt_take  = cmd_ok && !cnt_wr && !cnt_owr && pop_cnt;

    lp_push = start_take && !loop_full && !ret_full;
    rt_push = lp_push;
    lp_pop  = loop_exit || (ploop_take && !loop_empty);
    rt_pop  = loop_exit && !ret_empty;
    cs_push = cmd_ok && cnt_wr && !cnt_full;
    cs_pop  = (loop_exit && top_is_ce && !cnt_empty) || (pcnt_take && !cnt_empty);

    cnt_ld_new  = cs_push || owr_take;
    cnt_restore = cs_pop;
    cnt_dec     = loop_back && top_is_ce;

    err_set = (start_take && (loop_full || ret_full))
            || (ploop_take && loop_empty)
            || (cmd_ok && cnt_wr && cnt_full)
            || (pcnt_take && cnt_empty)
            || (loop_exit && ret_empty)
            || (loop_exit && top_is_ce && cnt_empty);
    err_d = err_q || err_set;

    loop_new.end_addr = start_end_addr;
    loop_new.cond     = start_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= err_d;
  end
  assign stk_err = err_q;

  lnc_lifo #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stk (
    .clk(clk), .rst_n(rst_n), .push(lp_push), .pop(lp_pop),
    .wdata(loop_new), .top(loop_top), .full(loop_full), .empty(loop_empty)
  );

  lnc_lifo #(.W(LNC_AW), .DEPTH(RET_DEPTH)) u_ret_stk (
    .clk(clk), .rst_n(rst_n), .push(rt_push), .pop(rt_pop),
    .wdata(start_top_addr), .top(ret_top), .full(ret_full), .empty(ret_empty)
  );

  lnc_lifo #(.W(CW), .DEPTH(CNT_DEPTH)) u_cnt_stk (
    .clk(clk), .rst_n(rst_n), .push(cs_push), .pop(cs_pop),
    .wdata(cnt_value), .top(cs_top), .full(cnt_full), .empty(cnt_empty)
  );

  lnc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_new(cnt_ld_new), .new_val(cnt_wdata),
    .ld_restore(cnt_restore), .restore_val(cs_top), .dec(cnt_dec),
    .cnt_q(cnt_value), .expired(cnt_expired)
  );
endmodule

// File: rtl/loop_nest_ctrl_chk.sv
`timescale 1ns/1ps
module loop_nest_ctrl_chk #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loop_end_hit,
  input logic          loop_back,
  input logic          loop_exit,
  input logic          loop_empty,
  input logic          loop_full,
  input logic          loop_start,
  input logic          cnt_wr,
  input logic          cnt_owr,
  input logic [CW-1:0] cnt_wdata,
  input logic [CW-1:0] cnt_value,
  input logic          cnt_full,
  input logic          cnt_empty,
  input logic          top_is_ce,
  input logic          stk_err
);
  AST_HIT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end_hit |-> (loop_back != loop_exit)); // R7

  AST_NO_HIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    loop_empty |-> !loop_end_hit); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R11

  AST_CE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_back && top_is_ce) |=> (cnt_value == $past(cnt_value) - CW'(1))); // R7

  AST_OWR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_end_hit && cnt_owr && !cnt_wr) |=>
      ((cnt_value == $past(cnt_wdata)) && $stable(cnt_empty) && $stable(cnt_full))); // R3

  AST_FULL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_end_hit && loop_start && loop_full) |=> (loop_full && stk_err)); // R11

  AST_EXIT_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_exit && loop_full) |=> !loop_full); // R9
endmodule

bind loop_nest_ctrl loop_nest_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_end_hit(loop_end_hit), .loop_back(loop_back),
  .loop_exit(loop_exit), .loop_empty(loop_empty), .loop_full(loop_full),
  .loop_start(loop_start), .cnt_wr(cnt_wr), .cnt_owr(cnt_owr),
  .cnt_wdata(cnt_wdata), .cnt_value(cnt_value), .cnt_full(cnt_full),
  .cnt_empty(cnt_empty), .top_is_ce(top_is_ce), .stk_err(stk_err)
);

// File: tb/loop_nest_ctrl_bench.sv
`timescale 1ns/1ps
module loop_nest_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        loop_start, cnt_wr, cnt_owr, pop_loop, pop_cnt, cond_met;
  logic [13:0] start_end_addr, start_top_addr, cnt_wdata, fetch_addr;
  logic [3:0]  start_cond;
  logic        loop_end_hit, loop_back, loop_exit, cnt_expired;
  logic [13:0] back_addr, cnt_value;
  logic        loop_full, loop_empty, cnt_full, cnt_empty, ret_full, ret_empty, stk_err;

  int vectors = 0;
  int fails   = 0;
  bit done_flag = 0;

  logic [13:0] m_cnt;
  logic [13:0] m_cq[$];
  logic [13:0] m_le[$];
  logic [3:0]  m_lc[$];
  logic [13:0] m_rq[$];
  bit          m_err;

  always #5 clk = ~clk;

  loop_nest_ctrl u_loop_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .loop_start(loop_start), .start_end_addr(start_end_addr),
    .start_cond(start_cond), .start_top_addr(start_top_addr), .cnt_wr(cnt_wr),
    .cnt_owr(cnt_owr), .cnt_wdata(cnt_wdata), .pop_loop(pop_loop), .pop_cnt(pop_cnt),
    .fetch_addr(fetch_addr), .cond_met(cond_met), .loop_end_hit(loop_end_hit),
    .loop_back(loop_back), .loop_exit(loop_exit), .back_addr(back_addr),
    .cnt_value(cnt_value), .cnt_expired(cnt_expired), .loop_full(loop_full),
    .loop_empty(loop_empty), .cnt_full(cnt_full), .cnt_empty(cnt_empty),
    .ret_full(ret_full), .ret_empty(ret_empty), .stk_err(stk_err)
  );

  task automatic cmp(string tag, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, name, act, exp);
    end
  endtask

  task automatic clear_in();
    loop_start = 0; cnt_wr = 0; cnt_owr = 0; pop_loop = 0; pop_cnt = 0; cond_met = 0;
    start_end_addr = 0; start_top_addr = 0; start_cond = 0; cnt_wdata = 0;
    fetch_addr = 14'h3FFF;
  endtask

  // one clock: compare against model, advance model at the edge
  task automatic cyc(string tag);
    bit hit, ce, fin;
    #1;
    hit = (m_le.size() > 0) && (fetch_addr == m_le[$]);
    ce  = (m_lc.size() > 0) && (m_lc[$] == 4'hE);
    fin = ce ? (m_cnt == 14'd1) : cond_met;
    cmp(tag, "loop_end_hit", loop_end_hit, hit);
    cmp(tag, "loop_back", loop_back, hit && !fin);
    cmp(tag, "loop_exit", loop_exit, hit && fin);
    if (hit && !fin) cmp(tag, "back_addr", back_addr, m_rq[$]);
    cmp(tag, "cnt_value", cnt_value, m_cnt);
    cmp(tag, "cnt_expired", cnt_expired, m_cnt == 14'd1);
    cmp(tag, "loop_full", loop_full, m_le.size() == 4);
    cmp(tag, "loop_empty", loop_empty, m_le.size() == 0);
    cmp(tag, "cnt_full", cnt_full, m_cq.size() == 4);
    cmp(tag, "cnt_empty", cnt_empty, m_cq.size() == 0);
    cmp(tag, "ret_full", ret_full, m_rq.size() == 16);
    cmp(tag, "ret_empty", ret_empty, m_rq.size() == 0);
    cmp(tag, "stk_err", stk_err, m_err);
    @(posedge clk);
    if (hit) begin
      if (fin) begin
        void'(m_le.pop_back()); void'(m_lc.pop_back());
        if (m_rq.size() > 0) void'(m_rq.pop_back()); else m_err = 1;
        if (ce) begin
          if (m_cq.size() > 0) m_cnt = m_cq.pop_back(); else m_err = 1;
        end
      end else if (ce) m_cnt = m_cnt - 14'd1;
    end else begin
      if (loop_start) begin
        if (m_le.size() == 4 || m_rq.size() == 16) m_err = 1;
        else begin
          m_le.push_back(start_end_addr); m_lc.push_back(start_cond);
          m_rq.push_back(start_top_addr);
        end
      end else if (pop_loop) begin
        if (m_le.size() == 0) m_err = 1;
        else begin void'(m_le.pop_back()); void'(m_lc.pop_back()); end
      end
      if (cnt_wr) begin
        if (m_cq.size() == 4) m_err = 1;
        else begin m_cq.push_back(m_cnt); m_cnt = cnt_wdata; end
      end else if (cnt_owr) m_cnt = cnt_wdata;
      else if (pop_cnt) begin
        if (m_cq.size() == 0) m_err = 1; else m_cnt = m_cq.pop_back();
      end
    end
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_in();
    m_cnt = 0; m_err = 0;
    m_cq.delete(); m_le.delete(); m_lc.delete(); m_rq.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic start(logic [13:0] e, logic [3:0] c, logic [13:0] t, string tag);
    loop_start = 1; start_end_addr = e; start_cond = c; start_top_addr = t;
    cyc(tag);
  endtask

  task automatic wr(logic [13:0] v, string tag);
    cnt_wr = 1; cnt_wdata = v; cyc(tag);
  endtask

  task automatic fetch(logic [13:0] a, logic cm, string tag);
    fetch_addr = a; cond_met = cm; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    cyc("R1"); cyc("R1");

    // R2: saving loads up to a full count stack
    wr(14'd5, "R2"); wr(14'd7, "R2"); wr(14'd9, "R2"); wr(14'd11, "R2");
    cyc("R2");
    // R4: restore
    pop_cnt = 1; cyc("R4");
    pop_cnt = 1; cyc("R4");
    // R3: overwrite, no save
    cnt_owr = 1; cnt_wdata = 14'd20; cyc("R3");
    cyc("R3");

    do_reset();
    // counted loop, three passes
    wr(14'd3, "R2");
    start(14'h100, 4'hE, 14'h0F0, "R5");
    fetch(14'h0F0, 0, "R6");
    fetch(14'h100, 0, "R7");
    fetch(14'h100, 0, "R7");
    fetch(14'h100, 0, "R9");
    cyc("R9");

    // R8: externally decided loop
    start(14'h200, 4'h3, 14'h1F0, "R5");
    fetch(14'h200, 0, "R8");
    fetch(14'h200, 1, "R8");
    cyc("R8");

    // nested: counted outer, conditional inner
    wr(14'd2, "R2");
    start(14'h300, 4'hE, 14'h2C0, "R5");
    start(14'h2F0, 4'h5, 14'h2D0, "R5");
    fetch(14'h2F0, 0, "R8");
    fetch(14'h2F0, 1, "R9");
    fetch(14'h300, 1, "R7");
    fetch(14'h300, 0, "R9");
    cyc("R9");

    // R10: commands in a hit cycle and conflicting commands
    wr(14'd4, "R2");
    start(14'h400, 4'hE, 14'h3C0, "R5");
    fetch_addr = 14'h400; cnt_wr = 1; cnt_wdata = 14'd99; loop_start = 1;
    start_end_addr = 14'h500; start_top_addr = 14'h4F0; pop_cnt = 1;
    cyc("R10");
    cnt_wr = 1; cnt_owr = 1; cnt_wdata = 14'd50; cyc("R10");
    cnt_owr = 1; pop_cnt = 1; cnt_wdata = 14'd60; cyc("R10");
    loop_start = 1; pop_loop = 1; start_end_addr = 14'h500; start_cond = 4'h2;
    start_top_addr = 14'h4F0; cyc("R10");
    cyc("R10");
    // R12: manual loop pop leaves return stack
    pop_loop = 1; cyc("R12");
    pop_loop = 1; cyc("R12");
    cyc("R12");

    // R11: overflow and underflow cases
    do_reset();
    for (int i = 0; i < 4; i++) start(14'h600 + 14'(i), 4'h1, 14'h5F0, "R11");
    start(14'h700, 4'h1, 14'h6F0, "R11");
    fetch(14'h700, 1, "R11");
    cyc("R11");
    do_reset();
    pop_loop = 1; cyc("R11"); cyc("R11");
    do_reset();
    pop_cnt = 1; cyc("R11"); cyc("R11");
    do_reset();
    for (int i = 0; i < 4; i++) wr(14'(i + 1), "R11");
    wr(14'd77, "R11");
    cyc("R11");
    do_reset();
    cnt_owr = 1; cnt_wdata = 14'd1; cyc("R3");
    start(14'h800, 4'hE, 14'h7F0, "R5");
    fetch(14'h800, 0, "R11");
    cyc("R11");

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule